// File: doc/BRIEF.md
# SIMD Saturating Integer Lane ALU

This block is a vector integer unit for a 128-bit datapath. Two 128-bit operands are split into sixteen 8-bit, eight 16-bit or four 32-bit lanes. Lane 0 is always the most significant slice of the vector. Each accepted instruction performs one lane-wise operation: a saturating add or subtract (signed or unsigned), a rounded-up average, or a narrowing pack with saturation from a wide lane type to the next narrower one. The result is registered and appears one cycle later together with a valid strobe.

Each instruction also yields a single saturation indication, which is the OR of the per-lane clamp events. That indication sets a sticky status bit. The sticky bit stays set until an explicit clear input is applied, so a sequence of instructions can be checked for precision loss with a single read at the end.

Opcode encoding on `op_i`: 0 saturating add, 1 saturating subtract, 2 average, 3 pack signed-to-signed, 4 pack signed-to-unsigned, 5 pack unsigned-to-unsigned, 6 and 7 undefined. Size encoding on `size_i`: 0 is 8-bit lanes, 1 is 16-bit lanes, 2 is 32-bit lanes and 3 is undefined. For a pack, `size_i` gives the narrow destination lane width: 0 packs 16 to 8 bits and 1 packs 32 to 16 bits.

Top module: `simd_sat_alu`

## Requirements
- R1: Lane k of a vector with lane width w occupies bits [127-w*k : 128-w*(k+1)], so lane 0 is the most significant slice.
- R2: Unsigned add returns the lane's all-ones value when the true sum does not fit, and flags saturation in that case.
- R3: Unsigned subtract returns zero and flags saturation whenever the subtrahend lane (`b_i`) is larger than the minuend lane (`a_i`).
- R4: Signed add and subtract (`signed_i`=1) clamp the exact result to the signed lane range, the minimum for negative overflow and the maximum for positive overflow, and flag saturation.
- R5: Average returns floor((a+b+1)/2), computed without overflow, for signed or unsigned lanes, and never flags saturation.
- R6: Pack signed-to-signed (op 3) clamps each signed wide source to the signed range of the narrow lane, flagging saturation when it clamps.
- R7: Pack signed-to-unsigned (op 4) gives 0 for negative sources and the narrow all-ones value for sources above it, flagging saturation in both cases.
- R8: Pack unsigned-to-unsigned (op 5) clamps only at the narrow all-ones value, flagging saturation when it does.
- R9: A pack places the narrowed lanes of `a_i` in the upper half of the result (lanes 0 to n/2-1) and those of `b_i` in the lower half, each in source lane order.
- R10: An instruction accepted with `valid_i` produces `valid_o`, `res_o` and `sat_o` exactly one cycle later. `sat_o` is the OR of all lane saturations of that instruction, and it is 0 in any cycle without `valid_o`.
- R11: The sticky bit is set by any instruction that saturates and is cleared only by `clr_sat_i`. When a saturating instruction and a clear arrive in the same cycle, the set wins.
- R12: Opcodes 6 and 7, size code 3, and a pack with size code 2 all return a zero result and no saturation. `signed_i` has no effect on a pack.
- R13: While `rst_ni` is low, `valid_o`, `res_o`, `sat_o` and `sticky_o` are all 0.
- R14: In a cycle without an instruction, `res_o` holds the previous result and the operand inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Lane width select (destination width for packs) |
| signed_i | input | 1 | Signed lanes for add, subtract and average |
| a_i | input | 128 | First operand; upper half source for packs |
| b_i | input | 128 | Second operand; lower half source for packs |
| clr_sat_i | input | 1 | Clear the sticky saturation bit |
| valid_o | output | 1 | Result valid strobe |
| res_o | output | 128 | Registered result vector |
| sat_o | output | 1 | Saturation indication of the returned instruction |
| sticky_o | output | 1 | Sticky saturation status |

## Verification
The only internal state is the result register, the valid and per-instruction saturation flops, and the sticky bit, so any corruption shows at the ports on the next edge. A wrong lane clamp or a misplaced lane appears in `res_o` on the cycle after the instruction. A lost or spurious lane saturation changes `sat_o` in that same cycle. A wrongly held or dropped sticky bit shows on the first cycle it should differ, even when no other instruction follows, because the bench compares `sticky_o` against its own model every cycle, idle cycles included. Operand values are chosen near the lane limits so that clamping, the boundary next to it, and the mixing of lanes are all exercised.

// File: rtl/simd_sat_alu_pkg.sv
package simd_sat_alu_pkg;
  localparam int OP_W = 3;
  localparam int SZ_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AVG   = 3'd2,
    OP_PK_SS = 3'd3,
    OP_PK_SU = 3'd4,
    OP_PK_UU = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    PK_SS = 2'd0,
    PK_SU = 2'd1,
    PK_UU = 2'd2
  } pk_mode_e;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
  import simd_sat_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  input  logic         signed_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam int EW = W + 1;

  logic [EW-1:0] ax, bx, sum, dif, avg, pick;
  logic [W-1:0]  smax, smin;

  // extend one bit: sign or zero depending on mode
  assign ax   = {signed_i & a_i[W-1], a_i};
  assign bx   = {signed_i & b_i[W-1], b_i};
  assign sum  = ax + bx;
  assign dif  = ax - bx;
  assign avg  = ax + bx + EW'(1);
  assign pick = (op_i == OP_SUB) ? dif : sum;
  assign smax = {1'b0, {(W-1){1'b1}}};
  assign smin = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    res_o = '0;
    sat_o = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        if (signed_i) begin
          if (pick[W] != pick[W-1]) begin
            sat_o = 1'b1;
            res_o = pick[W] ? smin : smax;
          end else begin
            res_o = pick[W-1:0];
          end
        end else if (op_i == OP_ADD) begin
          if (sum[W]) begin
            sat_o = 1'b1;
            res_o = '1;
          end else begin
            res_o = sum[W-1:0];
          end
        end else begin
          if (dif[W]) begin
            sat_o = 1'b1;
            res_o = '0;
          end else begin
            res_o = dif[W-1:0];
          end
        end
      end
      OP_AVG:  res_o = avg[W:1];
      default: ;
    endcase
  end
endmodule

// File: rtl/simd_vec_arith.sv
module simd_vec_arith
  import simd_sat_alu_pkg::*;
#(
  parameter int VW = 128,
  parameter int W  = 8
) (
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  input  alu_op_e       op_i,
  input  logic          signed_i,
  output logic [VW-1:0] res_o,
  output logic          sat_o
);
  localparam int NL = VW / W;

  logic [NL-1:0] lane_sat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    simd_lane_arith #(.W(W)) u_lane (
      .a_i     (a_i[VW-1-W*i -: W]),
      .b_i     (b_i[VW-1-W*i -: W]),
      .op_i    (op_i),
      .signed_i(signed_i),
      .res_o   (res_o[VW-1-W*i -: W]),
      .sat_o   (lane_sat[i])
    );
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/simd_vec_pack.sv
module simd_vec_pack
  import simd_sat_alu_pkg::*;
#(
  parameter int VW = 128,
  parameter int DW = 8
) (
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  input  pk_mode_e      mode_i,
  output logic [VW-1:0] res_o,
  output logic          sat_o
);
  localparam int SW   = 2 * DW;
  localparam int NL   = VW / DW;
  localparam int HALF = NL / 2;

  logic [NL-1:0] lane_sat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [SW-1:0] src;
    logic [DW-1:0] nar;
    logic          sat;

    // upper half of the result comes from a_i, lower half from b_i
    if (i < HALF) begin : g_a
      assign src = a_i[VW-1-SW*i -: SW];
    end else begin : g_b
      assign src = b_i[VW-1-SW*(i-HALF) -: SW];
    end

    always_comb begin
      nar = src[DW-1:0];
      sat = 1'b0;
      case (mode_i)
        PK_SS: begin
          if (!(&src[SW-1:DW-1]) && (|src[SW-1:DW-1])) begin
            sat = 1'b1;
            nar = src[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
          end
        end
        PK_SU: begin
          if (src[SW-1]) begin
            sat = 1'b1;
            nar = '0;
          end else if (|src[SW-2:DW]) begin
            sat = 1'b1;
            nar = '1;
          end
        end
        PK_UU: begin
          if (|src[SW-1:DW]) begin
            sat = 1'b1;
            nar = '1;
          end
        end
        default: ;
      endcase
    end

    assign res_o[VW-1-DW*i -: DW] = nar;
    assign lane_sat[i]            = sat;
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_sat_alu_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BASE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             signed_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             clr_sat_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o,
  output logic             sticky_o
);
  localparam int N_AR = 3;
  localparam int N_PK = 2;

  alu_op_e  op;
  pk_mode_e pk_mode;
  logic     is_arith, is_pack;

  logic [N_AR-1:0][VEC_W-1:0] ar_res;
  logic [N_AR-1:0]            ar_sat;
  logic [N_PK-1:0][VEC_W-1:0] pk_res;
  logic [N_PK-1:0]            pk_sat;

  logic [VEC_W-1:0] res_d;
  logic             sat_d;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AVG);
  assign is_pack  = (op == OP_PK_SS) || (op == OP_PK_SU) || (op == OP_PK_UU);

  always_comb begin
    case (op)
      OP_PK_SU: pk_mode = PK_SU;
      OP_PK_UU: pk_mode = PK_UU;
      default:  pk_mode = PK_SS;
    endcase
  end

  for (genvar g = 0; g < N_AR; g++) begin : g_arith
    simd_vec_arith #(.VW(VEC_W), .W(BASE_W << g)) u_arith (
      .a_i     (a_i),
      .b_i     (b_i),
      .op_i    (op),
      .signed_i(signed_i),
      .res_o   (ar_res[g]),
      .sat_o   (ar_sat[g])
    );
  end

  for (genvar g = 0; g < N_PK; g++) begin : g_pack
    simd_vec_pack #(.VW(VEC_W), .DW(BASE_W << g)) u_pack (
      .a_i   (a_i),
      .b_i   (b_i),
      .mode_i(pk_mode),
      .res_o (pk_res[g]),
      .sat_o (pk_sat[g])
    );
  end

  // undefined op or size falls through to zero with no saturation
  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    if (is_arith) begin
      for (int k = 0; k < N_AR; k++) begin
        if (int'(size_i) == k) begin
          res_d = ar_res[k];
          sat_d = ar_sat[k];
        end
      end
    end else if (is_pack) begin
      for (int k = 0; k < N_PK; k++) begin
        if (int'(size_i) == k) begin
          res_d = pk_res[k];
          sat_d = pk_sat[k];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      res_o    <= '0;
      sat_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sat_o   <= valid_i & sat_d;
      if (valid_i) res_o <= res_d;
      // set takes priority over clear
      if (valid_i && sat_d)  sticky_o <= 1'b1;
      else if (clr_sat_i)    sticky_o <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
  import simd_sat_alu_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  op_i,
  input logic             clr_sat_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] res_o,
  input logic             sat_o,
  input logic             sticky_o
);
  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !sat_o));

  assert_sat_has_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> valid_o);

  assert_sat_sets_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> sticky_o);

  assert_sticky_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_o) |-> sat_o);

  assert_sticky_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sticky_o) |-> $past(clr_sat_i));

  assert_avg_no_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_AVG) |=> !sat_o);

  assert_bad_op_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd5) |=> (res_o == '0 && !sat_o));

  assert_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         valid_i;
  logic [2:0]   op_i;
  logic [1:0]   size_i;
  logic         signed_i;
  logic [127:0] a_i, b_i;
  logic         clr_sat_i;
  logic         valid_o;
  logic [127:0] res_o;
  logic         sat_o;
  logic         sticky_o;

  always #2 clk_i = ~clk_i;

  simd_sat_alu dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .signed_i(signed_i), .a_i(a_i), .b_i(b_i),
    .clr_sat_i(clr_sat_i), .valid_o(valid_o), .res_o(res_o),
    .sat_o(sat_o), .sticky_o(sticky_o)
  );

  int           checks = 0;
  int           fails  = 0;
  bit           exp_sticky = 1'b0;
  bit           finished = 1'b0;
  logic [127:0] last_res = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint fld(input logic [127:0] v, input int w, input int idx);
    logic [127:0] t;
    logic [63:0]  m;
    t = v >> (128 - w * (idx + 1));
    m = (64'd1 << w) - 64'd1;
    return longint'(t[63:0] & m);
  endfunction

  // behavioural reference from the requirements
  function automatic void ref_vec(input int op, input int sz, input bit sg,
                                  input logic [127:0] a, input logic [127:0] b,
                                  output logic [127:0] r, output bit s);
    int          w, n;
    longint      x, y, v, lo, hi;
    longint      one;
    logic [63:0] m, vv;
    r = '0;
    s = 1'b0;
    one = 1;
    if (op > 5 || sz > 2 || (op >= 3 && sz > 1)) return;
    w = 8 << sz;
    n = 128 / w;
    m = (64'd1 << w) - 64'd1;
    for (int i = 0; i < n; i++) begin
      if (op < 3) begin
        x = fld(a, w, i);
        y = fld(b, w, i);
        if (sg) begin
          if (x >= (one << (w - 1))) x = x - (one << w);
          if (y >= (one << (w - 1))) y = y - (one << w);
          lo = -(one << (w - 1));
          hi = (one << (w - 1)) - 1;
        end else begin
          lo = 0;
          hi = (one << w) - 1;
        end
        if (op == 0)      v = x + y;
        else if (op == 1) v = x - y;
        else              v = (x + y + 1) >>> 1;
        if (op != 2) begin
          if (v > hi) begin v = hi; s = 1'b1; end
          else if (v < lo) begin v = lo; s = 1'b1; end
        end
      end else begin
        if (i < n / 2) x = fld(a, 2 * w, i);
        else           x = fld(b, 2 * w, i - n / 2);
        if (op != 5 && x >= (one << (2 * w - 1))) x = x - (one << (2 * w));
        if (op == 3) begin
          lo = -(one << (w - 1));
          hi = (one << (w - 1)) - 1;
        end else begin
          lo = 0;
          hi = (one << w) - 1;
        end
        v = x;
        if (v > hi) begin v = hi; s = 1'b1; end
        else if (v < lo) begin v = lo; s = 1'b1; end
      end
      vv = v;
      vv = vv & m;
      r = r | ({64'd0, vv} << (128 - w * (i + 1)));
    end
  endfunction

  function automatic string tag_of(input int op, input int sz, input bit sg);
    if (op > 5 || sz > 2 || (op >= 3 && sz > 1)) return "R12";
    case (op)
      0: return sg ? "R4" : "R2";
      1: return sg ? "R4" : "R3";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input int op, input int sz, input bit sg,
                     input logic [127:0] a, input logic [127:0] b, input bit clr);
    logic [127:0] er;
    bit           es;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'(op); size_i = 2'(sz); signed_i = sg;
    a_i = a; b_i = b; clr_sat_i = clr;
    ref_vec(op, sz, sg, a, b, er, es);
    if (es)       exp_sticky = 1'b1;
    else if (clr) exp_sticky = 1'b0;
    @(posedge clk_i);
    #1;
    chk(valid_o === 1'b1, "R10", "valid_o", 128'(valid_o), 128'd1);
    chk(res_o === er, tag_of(op, sz, sg), "res_o", res_o, er);
    chk(sat_o === es, "R10", "sat_o", 128'(sat_o), 128'(es));
    chk(sticky_o === exp_sticky, "R11", "sticky_o", 128'(sticky_o), 128'(exp_sticky));
    last_res = er;
  endtask

  task automatic idle(input bit clr);
    @(negedge clk_i);
    valid_i = 1'b0; clr_sat_i = clr;
    a_i = {4{$urandom}}; b_i = {4{$urandom}}; op_i = 3'($urandom); signed_i = 1'($urandom);
    if (clr) exp_sticky = 1'b0;
    @(posedge clk_i);
    #1;
    chk(valid_o === 1'b0, "R14", "idle valid_o", 128'(valid_o), 128'd0);
    chk(sat_o === 1'b0, "R10", "idle sat_o", 128'(sat_o), 128'd0);
    chk(res_o === last_res, "R14", "idle res_o", res_o, last_res);
    chk(sticky_o === exp_sticky, "R11", "idle sticky_o", 128'(sticky_o), 128'(exp_sticky));
  endtask

  function automatic logic [127:0] rnd_vec();
    logic [127:0] v;
    for (int k = 0; k < 4; k++) begin
      case ($urandom % 5)
        0: v[32*k +: 32] = 32'h7f7f7f7f ^ ($urandom & 32'h01010101);
        1: v[32*k +: 32] = 32'h80808080 | ($urandom & 32'h01010101);
        2: v[32*k +: 32] = $urandom & 32'h00ff00ff;
        3: v[32*k +: 32] = 32'hffffffff ^ ($urandom & 32'h03030303);
        default: v[32*k +: 32] = $urandom;
      endcase
    end
    return v;
  endfunction

  initial begin
    logic [127:0] r_a;
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; size_i = '0; signed_i = 1'b0;
    a_i = '0; b_i = '0; clr_sat_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R13 reset state
    chk(valid_o === 1'b0, "R13", "reset valid_o", 128'(valid_o), 128'd0);
    chk(res_o === '0, "R13", "reset res_o", res_o, 128'd0);
    chk(sat_o === 1'b0, "R13", "reset sat_o", 128'(sat_o), 128'd0);
    chk(sticky_o === 1'b0, "R13", "reset sticky_o", 128'(sticky_o), 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 only lane 0 saturates; it is the top byte
    run(0, 0, 1'b0, {8'hFF, 8'h10, 112'h0}, {8'h01, 8'h20, 112'h0}, 1'b0);
    chk(res_o === {8'hFF, 8'h30, 112'h0}, "R1", "lane0 position", res_o, {8'hFF, 8'h30, 112'h0});
    idle(1'b1);
    // R2 unsigned byte add overflow everywhere
    run(0, 0, 1'b0, {16{8'hF0}}, {16{8'h20}}, 1'b0);
    chk(res_o === {16{8'hFF}}, "R2", "all ones", res_o, {16{8'hFF}});
    // R3 unsigned halfword subtract underflow
    run(1, 1, 1'b0, {8{16'd5}}, {8{16'd10}}, 1'b1);
    chk(res_o === '0, "R3", "zero result", res_o, 128'd0);
    // R4 signed word clamps
    run(0, 2, 1'b1, {4{32'h7fffffff}}, {4{32'd1}}, 1'b0);
    chk(res_o === {4{32'h7fffffff}}, "R4", "max clamp", res_o, {4{32'h7fffffff}});
    run(1, 2, 1'b1, {4{32'h80000000}}, {4{32'd1}}, 1'b0);
    chk(res_o === {4{32'h80000000}}, "R4", "min clamp", res_o, {4{32'h80000000}});
    // R5 averages round up, no saturation
    run(2, 0, 1'b1, {16{8'hFF}}, {16{8'h00}}, 1'b1);
    chk(res_o === '0, "R5", "signed avg -1,0", res_o, 128'd0);
    run(2, 0, 1'b0, {16{8'hFF}}, {16{8'hFF}}, 1'b0);
    chk(res_o === {16{8'hFF}} && sat_o === 1'b0, "R5", "unsigned avg max", res_o, {16{8'hFF}});
    // R9 pack placement
    run(5, 0, 1'b0, {8{16'h0011}}, {8{16'h0022}}, 1'b0);
    chk(res_o === {{8{8'h11}}, {8{8'h22}}}, "R9", "pack halves", res_o, {{8{8'h11}}, {8{8'h22}}});
    // R7 negative to zero, large to all ones
    run(4, 0, 1'b0, {8{16'hFF80}}, {8{16'h0100}}, 1'b0);
    chk(res_o === {64'h0, {8{8'hFF}}}, "R7", "su clamp", res_o, {64'h0, {8{8'hFF}}});
    // R6 signed pack
    run(3, 1, 1'b0, {4{32'hFFFF0000}}, {4{32'h00012345}}, 1'b0);
    chk(res_o === {{4{16'h8000}}, {4{16'h7FFF}}}, "R6", "ss clamp", res_o, {{4{16'h8000}}, {4{16'h7FFF}}});
    // R12 signed_i ignored for packs
    run(4, 1, 1'b1, {4{32'hFFFF0000}}, {4{32'h00001234}}, 1'b0);
    r_a = res_o;
    run(4, 1, 1'b0, {4{32'hFFFF0000}}, {4{32'h00001234}}, 1'b0);
    chk(res_o === r_a, "R12", "pack signed_i ignored", res_o, r_a);
    run(6, 0, 1'b0, {16{8'hF0}}, {16{8'h20}}, 1'b0);
    run(0, 3, 1'b0, {16{8'hF0}}, {16{8'h20}}, 1'b0);
    run(3, 2, 1'b1, {16{8'h80}}, {16{8'h7F}}, 1'b0);
    // R11 sticky: set wins over clear, clear without sat, idle holds
    idle(1'b1);
    run(0, 0, 1'b0, {16{8'hF0}}, {16{8'h20}}, 1'b1);
    chk(sticky_o === 1'b1, "R11", "set beats clear", 128'(sticky_o), 128'd1);
    idle(1'b0);
    run(0, 0, 1'b0, '0, '0, 1'b0);
    chk(sticky_o === 1'b1, "R11", "held over non-sat op", 128'(sticky_o), 128'd1);
    run(0, 0, 1'b0, '0, '0, 1'b1);
    chk(sticky_o === 1'b0, "R11", "explicit clear", 128'(sticky_o), 128'd0);
    idle(1'b0);

    // random sweep over every op, size and sign
    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int it = 0; it < 40; it++) begin
            run(op, sz, 1'(sg), rnd_vec(), rnd_vec(), 1'(($urandom % 4) == 0));
            if (($urandom % 8) == 0) idle(1'(($urandom % 2)));
          end
        end
      end
    end

    idle(1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule